// File: doc/BRIEF.md
# Multi-Mode Tuning-Word Sequencer for a DDS

This block sits between a command source and an external direct digital synthesizer. It receives tuning words that are already computed and decides which word to write, and when, for the selected operating mode. Writes leave the block as a single-cycle strobe with a 32-bit data word. The block also drives a 2-bit profile select, a chirp restart pulse and a convert pulse for an external ADC.

Five mode codes are decoded. Fixed tone writes one word per command. Time-multiplexed rotation steps the profile select through up to four slots on a programmable dwell count. Binary FSK writes one of two words chosen by a modulating bit. Chirp issues a periodic restart pulse that sends the sweep back to its start frequency. FM paces the ADC every 50 cycles and writes a retuned word for each returned sample. The bus that carries words into the synthesizer, and the analog chain, sit outside this block.

Top module: `dds_seq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, wrStrobe, restartPulse and adcConvert are 0, profileSel is 0 and wrData is 0.
- R2: In fixed mode (code 0), a cmdStrobe raises wrStrobe for exactly one cycle in the cycle after it. wrData carries tuneWord0 in that cycle.
- R3: A change of the mode input to a code 0 to 4 forces profileSel to 0 in the next cycle and writes once in that cycle. The word written is tuneWord0, or for BFSK (code 2) the word picked by modBit. Codes 5 to 7 are idle and produce no writes.
- R4: In TDM mode (code 1) with a dwell count D greater than 0, profileSel advances every D cycles, counted from the mode change. It steps 0, 1, ... up to profileLast and then wraps to 0. Each advance writes the tuneWord of the new slot in the same cycle.
- R5: A dwell count of 0 holds profileSel and suppresses TDM writes. A restart count of 0 suppresses restart pulses.
- R6: In BFSK mode, a change of modBit writes tuneWord1 (bit 1) or tuneWord0 (bit 0) in the next cycle.
- R7: In chirp mode (code 3) with a restart count C greater than 0, restartPulse is high for one cycle every C cycles, counted from the mode change.
- R8: In FM mode (code 4), adcConvert is high for one cycle every 50 cycles, counted from the mode change. It never pulses in other modes.
- R9: In FM mode, adcValid writes a word in the next cycle. The word is tuneWord0 + ((adcData × devWord) >>> 11), where adcData is a 12-bit two's-complement value and devWord is unsigned. The result is clamped to 0 and to 2^32−1.
- R10: In FM mode, cmdStrobe alone rewrites tuneWord0. When adcValid and cmdStrobe arrive in the same cycle, only the FM word is written.
- R11: adcValid has no effect outside FM mode. cmdStrobe has no effect in TDM, BFSK and chirp modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Mode code: 0 fixed, 1 TDM, 2 BFSK, 3 chirp, 4 FM, others idle |
| cmdStrobe | input | 1 | Command pulse requesting a rewrite of tuneWord0 |
| tuneWord0 | input | 32 | Slot 0 word; fixed tone, chirp start, FM center |
| tuneWord1 | input | 32 | Slot 1 word; BFSK mark word |
| tuneWord2 | input | 32 | Slot 2 word |
| tuneWord3 | input | 32 | Slot 3 word |
| devWord | input | 32 | FM deviation word, unsigned |
| profileLast | input | 2 | Highest slot used in TDM rotation |
| dwellCycles | input | 16 | TDM dwell count in cycles |
| restartCycles | input | 16 | Chirp restart interval in cycles |
| modBit | input | 1 | BFSK modulating bit |
| adcValid | input | 1 | ADC sample valid pulse |
| adcData | input | 12 | ADC sample, two's complement |
| wrStrobe | output | 1 | One-cycle tuning-word write strobe |
| wrData | output | 32 | Tuning word, valid with wrStrobe |
| profileSel | output | 2 | Profile select to the synthesizer |
| restartPulse | output | 1 | Chirp restart pulse |
| adcConvert | output | 1 | ADC convert pulse |

## Verification
A wrong interval counter or a missed counter clear on a mode change shows up as a pulse or profile step one or more cycles off its expected position. This is visible at the first period boundary after the mode change, so every interval check samples the cycle before, at, and after the boundary. A wrong word selection or wrong FM arithmetic shows up on the next write as a data mismatch against an independently computed word. Stray writes from ignored inputs show up as unexpected strobes in the following cycle.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam logic [2:0] MODE_FIXED = 3'd0;
  localparam logic [2:0] MODE_TDM   = 3'd1;
  localparam logic [2:0] MODE_BFSK  = 3'd2;
  localparam logic [2:0] MODE_CHIRP = 3'd3;
  localparam logic [2:0] MODE_FM    = 3'd4;

  // Write request from control to datapath
  typedef struct packed {
    logic       wrSel;   // write the bank word at selIdx
    logic       wrFm;    // write the FM-computed word (wins over wrSel)
    logic [1:0] selIdx;
  } wrCmdT;
endpackage

// File: rtl/dds_seq_ctrl.sv
module dds_seq_ctrl
  import dds_seq_pkg::*;
#(
  parameter int IVL_W      = 16,
  parameter int ADC_PERIOD = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       mode,
  input  logic             cmdStrobe,
  input  logic [1:0]       profileLast,
  input  logic [IVL_W-1:0] dwellCycles,
  input  logic [IVL_W-1:0] restartCycles,
  input  logic             modBit,
  input  logic             adcValid,
  output wrCmdT            cmd,
  output logic [1:0]       profileSel,
  output logic             restartPulse,
  output logic             adcConvert
);
  localparam int ADC_CNT_W = $clog2(ADC_PERIOD);

  logic [2:0]           modeReg;
  logic                 bitPrev;
  logic [IVL_W-1:0]     dwellCnt;
  logic [IVL_W-1:0]     restartCnt;
  logic [ADC_CNT_W-1:0] adcCnt;
  logic                 entry, validMode, advance, restartHit, adcHit;
  logic [1:0]           nextProfile;

  assign entry       = (mode != modeReg);
  assign validMode   = (mode <= MODE_FM);
  assign nextProfile = (profileSel >= profileLast) ? 2'd0 : profileSel + 2'd1;
  assign advance     = !entry && (mode == MODE_TDM) && (dwellCycles != '0) &&
                       (dwellCnt >= dwellCycles - IVL_W'(1));
  assign restartHit  = (restartCycles != '0) &&
                       (restartCnt >= restartCycles - IVL_W'(1));
  assign adcHit      = (adcCnt >= ADC_CNT_W'(ADC_PERIOD - 1));

  always_comb begin
    cmd.wrFm   = (mode == MODE_FM) && adcValid;
    cmd.wrSel  = 1'b0;
    cmd.selIdx = 2'd0;
    if (entry) begin
      cmd.wrSel  = validMode;
      cmd.selIdx = (mode == MODE_BFSK) ? {1'b0, modBit} : 2'd0;
    end else begin
      case (mode)
        MODE_FIXED, MODE_FM: cmd.wrSel = cmdStrobe;
        MODE_TDM: begin
          cmd.wrSel  = advance;
          cmd.selIdx = nextProfile;
        end
        MODE_BFSK: begin
          cmd.wrSel  = (modBit != bitPrev);
          cmd.selIdx = {1'b0, modBit};
        end
        default: cmd.wrSel = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg      <= MODE_FIXED;
      bitPrev      <= 1'b0;
      dwellCnt     <= '0;
      restartCnt   <= '0;
      adcCnt       <= '0;
      profileSel   <= 2'd0;
      restartPulse <= 1'b0;
      adcConvert   <= 1'b0;
    end else begin
      modeReg      <= mode;
      bitPrev      <= modBit;
      restartPulse <= 1'b0;
      adcConvert   <= 1'b0;
      if (entry) begin
        dwellCnt   <= '0;
        restartCnt <= '0;
        adcCnt     <= '0;
        profileSel <= 2'd0;
      end else begin
        case (mode)
          MODE_TDM: if (dwellCycles != '0) begin
            if (advance) begin
              dwellCnt   <= '0;
              profileSel <= nextProfile;
            end else begin
              dwellCnt <= dwellCnt + IVL_W'(1);
            end
          end
          MODE_CHIRP: if (restartCycles != '0) begin
            if (restartHit) begin
              restartCnt   <= '0;
              restartPulse <= 1'b1;
            end else begin
              restartCnt <= restartCnt + IVL_W'(1);
            end
          end
          MODE_FM: begin
            if (adcHit) begin
              adcCnt     <= '0;
              adcConvert <= 1'b1;
            end else begin
              adcCnt <= adcCnt + ADC_CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ENTRY_PROFILE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mode != modeReg) |=> (profileSel == 2'd0)); // R3
  AST_PROFILE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TDM && modeReg == MODE_TDM && dwellCycles == '0) |=> $stable(profileSel)); // R5
  AST_RESTART_CHIRP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> (modeReg == MODE_CHIRP)); // R7
  AST_CONVERT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    adcConvert |=> !adcConvert); // R8
endmodule

// File: rtl/dds_seq_dp.sv
module dds_seq_dp
  import dds_seq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int SAMPLE_W = 12,
  parameter int FM_SHIFT = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrCmdT               cmd,
  input  logic [WORD_W-1:0]   tuneWord0,
  input  logic [WORD_W-1:0]   tuneWord1,
  input  logic [WORD_W-1:0]   tuneWord2,
  input  logic [WORD_W-1:0]   tuneWord3,
  input  logic [WORD_W-1:0]   devWord,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic                wrStrobe,
  output logic [WORD_W-1:0]   wrData
);
  localparam int PROD_W = SAMPLE_W + WORD_W + 1;
  localparam int SUM_W  = PROD_W + 1;

  logic [WORD_W-1:0]        bankWord;
  logic signed [PROD_W-1:0] prod, scaled;
  logic signed [SUM_W-1:0]  sum;
  logic [WORD_W-1:0]        fmWord;

  always_comb begin
    case (cmd.selIdx)
      2'd0:    bankWord = tuneWord0;
      2'd1:    bankWord = tuneWord1;
      2'd2:    bankWord = tuneWord2;
      default: bankWord = tuneWord3;
    endcase
  end

  assign prod   = $signed(adcData) * $signed({1'b0, devWord});
  assign scaled = prod >>> FM_SHIFT;
  assign sum    = $signed({{(SUM_W-WORD_W){1'b0}}, tuneWord0}) +
                  $signed({scaled[PROD_W-1], scaled});

  always_comb begin
    if (sum[SUM_W-1])
      fmWord = '0;
    else if (|sum[SUM_W-2:WORD_W])
      fmWord = '1;
    else
      fmWord = sum[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrData   <= '0;
    end else begin
      wrStrobe <= cmd.wrFm || cmd.wrSel;
      if (cmd.wrFm)
        wrData <= fmWord;
      else if (cmd.wrSel)
        wrData <= bankWord;
    end
  end

  AST_FM_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrFm && !adcData[SAMPLE_W-1]) |=> (wrData >= $past(tuneWord0))); // R9
  AST_FM_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrFm && adcData[SAMPLE_W-1]) |=> (wrData <= $past(tuneWord0))); // R9
endmodule

// File: rtl/dds_seq_top.sv
module dds_seq_top
  import dds_seq_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SAMPLE_W   = 12,
  parameter int FM_SHIFT   = 11,
  parameter int IVL_W      = 16,
  parameter int ADC_PERIOD = 50
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          mode,
  input  logic                cmdStrobe,
  input  logic [WORD_W-1:0]   tuneWord0,
  input  logic [WORD_W-1:0]   tuneWord1,
  input  logic [WORD_W-1:0]   tuneWord2,
  input  logic [WORD_W-1:0]   tuneWord3,
  input  logic [WORD_W-1:0]   devWord,
  input  logic [1:0]          profileLast,
  input  logic [IVL_W-1:0]    dwellCycles,
  input  logic [IVL_W-1:0]    restartCycles,
  input  logic                modBit,
  input  logic                adcValid,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic                wrStrobe,
  output logic [WORD_W-1:0]   wrData,
  output logic [1:0]          profileSel,
  output logic                restartPulse,
  output logic                adcConvert
);
  wrCmdT cmd;

  dds_seq_ctrl #(.IVL_W(IVL_W), .ADC_PERIOD(ADC_PERIOD)) uCtrl (
    .clk(clk), .rstN(rstN), .mode(mode), .cmdStrobe(cmdStrobe),
    .profileLast(profileLast), .dwellCycles(dwellCycles),
    .restartCycles(restartCycles), .modBit(modBit), .adcValid(adcValid),
    .cmd(cmd), .profileSel(profileSel), .restartPulse(restartPulse),
    .adcConvert(adcConvert)
  );

  dds_seq_dp #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W), .FM_SHIFT(FM_SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tuneWord0(tuneWord0), .tuneWord1(tuneWord1),
    .tuneWord2(tuneWord2), .tuneWord3(tuneWord3),
    .devWord(devWord), .adcData(adcData),
    .wrStrobe(wrStrobe), .wrData(wrData)
  );
endmodule

// File: tb/sim_dds_seq_top.sv
module sim_dds_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        cmdStrobe = 1'b0;
  logic [31:0] tuneWord0 = 32'h1111_0000, tuneWord1 = 32'h2222_0001;
  logic [31:0] tuneWord2 = 32'h3333_0002, tuneWord3 = 32'h4444_0003;
  logic [31:0] devWord = 32'h0001_0000;
  logic [1:0]  profileLast = 2'd2;
  logic [15:0] dwellCycles = 16'd5, restartCycles = 16'd7;
  logic        modBit = 1'b0, adcValid = 1'b0;
  logic [11:0] adcData = 12'd0;
  logic        wrStrobe, restartPulse, adcConvert;
  logic [31:0] wrData;
  logic [1:0]  profileSel;

  always #5 clk = ~clk;

  dds_seq_top u0 (.*);

  typedef struct { logic [31:0] d; string tag; } expT;
  expT expQ[$];
  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [31:0] d, input string tag);
    expT e;
    e.d = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] fmRef(input logic [31:0] c, input logic signed [11:0] s,
                                        input logic [31:0] dv);
    longint p, r;
    p = longint'(s) * longint'({32'b0, dv});
    r = longint'({32'b0, c}) + (p >>> 11);
    if (r < 0) return 32'h0;
    if (r > 64'sh0000_0000_FFFF_FFFF) return 32'hFFFF_FFFF;
    return r[31:0];
  endfunction

  // Monitor: every observed write is compared against the scoreboard
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R11 unexpected write actual=%h expected=none", wrData);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(e.tag, wrData, e.d);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          nChecks++; nFail++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    int pulses;
    logic [31:0] e;
    waitN(3);
    chk("R1 wrStrobe", {31'b0, wrStrobe}, 0);
    chk("R1 wrData", wrData, 0);
    chk("R1 profileSel", {30'b0, profileSel}, 0);
    chk("R1 restartPulse", {31'b0, restartPulse}, 0);
    chk("R1 adcConvert", {31'b0, adcConvert}, 0);
    rstN = 1'b1;
    waitN(1);
    chk("R1 no write after reset", {31'b0, wrStrobe}, 0);

    // Fixed mode
    cmdStrobe = 1'b1; pushExp(tuneWord0, "R2 fixed word");
    waitN(1); cmdStrobe = 1'b0;
    chk("R2 strobe next cycle", {31'b0, wrStrobe}, 1);
    waitN(1);
    chk("R2 strobe one cycle", {31'b0, wrStrobe}, 0);
    tuneWord0 = 32'h0ABC_DEF0;
    cmdStrobe = 1'b1; pushExp(32'h0ABC_DEF0, "R2 second word");
    waitN(1); cmdStrobe = 1'b0;
    waitN(2);

    // TDM rotation
    mode = 3'd1; pushExp(tuneWord0, "R3 TDM entry");
    pushExp(tuneWord1, "R4 slot1"); pushExp(tuneWord2, "R4 slot2");
    waitN(1);
    chk("R3 profile 0 on entry", {30'b0, profileSel}, 0);
    waitN(4); chk("R4 profile k4", {30'b0, profileSel}, 0);
    waitN(1); chk("R4 profile k5", {30'b0, profileSel}, 1);
    chk("R4 write with advance", {31'b0, wrStrobe}, 1);
    waitN(5); chk("R4 profile k10", {30'b0, profileSel}, 2);
    pushExp(tuneWord0, "R4 wrap");
    waitN(5); chk("R4 wrap to 0", {30'b0, profileSel}, 0);
    pushExp(tuneWord1, "R4 slot1 again"); pushExp(tuneWord2, "R4 slot2 again");
    waitN(10);
    chk("R4 profile 2 before hold", {30'b0, profileSel}, 2);
    dwellCycles = 16'd0;
    waitN(20);
    chk("R5 dwell zero holds profile", {30'b0, profileSel}, 2);

    // BFSK
    modBit = 1'b1; mode = 3'd2; pushExp(tuneWord1, "R3 BFSK entry word");
    waitN(1);
    chk("R3 profile cleared on mode change", {30'b0, profileSel}, 0);
    chk("R3 entry write", {31'b0, wrStrobe}, 1);
    waitN(2);
    modBit = 1'b0; pushExp(tuneWord0, "R6 space word");
    waitN(1); chk("R6 write next cycle", {31'b0, wrStrobe}, 1);
    waitN(2);
    modBit = 1'b1; pushExp(tuneWord1, "R6 mark word");
    waitN(3);
    cmdStrobe = 1'b1; waitN(1); cmdStrobe = 1'b0;
    chk("R11 cmdStrobe ignored in BFSK", {31'b0, wrStrobe}, 0);
    waitN(2);

    // Chirp
    mode = 3'd3; pushExp(tuneWord0, "R3 chirp start word");
    waitN(1);
    waitN(6); chk("R7 no pulse k6", {31'b0, restartPulse}, 0);
    waitN(1); chk("R7 pulse k7", {31'b0, restartPulse}, 1);
    waitN(1); chk("R7 pulse one cycle", {31'b0, restartPulse}, 0);
    waitN(6); chk("R7 pulse k14", {31'b0, restartPulse}, 1);
    restartCycles = 16'd0;
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      waitN(1);
      if (restartPulse) pulses++;
    end
    chk("R5 restart zero no pulses", pulses, 0);
    chk("R8 no convert in chirp", {31'b0, adcConvert}, 0);

    // FM
    tuneWord0 = 32'h4000_0000; devWord = 32'h0001_0000;
    mode = 3'd4; pushExp(32'h4000_0000, "R3 FM entry center");
    waitN(1);
    waitN(49); chk("R8 no convert k49", {31'b0, adcConvert}, 0);
    waitN(1);  chk("R8 convert k50", {31'b0, adcConvert}, 1);
    waitN(1);  chk("R8 convert one cycle", {31'b0, adcConvert}, 0);
    waitN(49); chk("R8 convert k100", {31'b0, adcConvert}, 1);

    adcData = 12'd100; adcValid = 1'b1;
    e = fmRef(tuneWord0, 12'sd100, devWord);
    chk("R9 reference positive", e, 32'h4000_0C80);
    pushExp(e, "R9 positive sample");
    waitN(1); adcValid = 1'b0;
    chk("R9 write next cycle", {31'b0, wrStrobe}, 1);
    adcData = 12'h800; adcValid = 1'b1;
    pushExp(fmRef(tuneWord0, -12'sd2048, devWord), "R9 negative sample");
    waitN(1); adcValid = 1'b0;
    tuneWord0 = 32'hFFFF_F000; devWord = 32'hFFFF_FFFF;
    adcData = 12'h7FF; adcValid = 1'b1;
    pushExp(32'hFFFF_FFFF, "R9 saturate high");
    waitN(1); adcValid = 1'b0;
    tuneWord0 = 32'h0000_0010; devWord = 32'h0010_0000;
    adcData = 12'hFFF; adcValid = 1'b1;
    pushExp(32'h0000_0000, "R9 saturate low");
    waitN(1); adcValid = 1'b0;
    tuneWord0 = 32'h4000_0000; devWord = 32'h0001_0000;
    adcData = 12'd100; adcValid = 1'b1; cmdStrobe = 1'b1;
    pushExp(32'h4000_0C80, "R10 FM wins");
    waitN(1); adcValid = 1'b0; cmdStrobe = 1'b0;
    waitN(1); chk("R10 single write", {31'b0, wrStrobe}, 0);
    cmdStrobe = 1'b1; pushExp(32'h4000_0000, "R10 center rewrite");
    waitN(1); cmdStrobe = 1'b0;
    waitN(2);

    // Idle code and ignored adcValid
    mode = 3'd5;
    waitN(1); chk("R3 idle code no write", {31'b0, wrStrobe}, 0);
    waitN(2);
    mode = 3'd0; pushExp(32'h4000_0000, "R3 fixed entry");
    waitN(2);
    adcValid = 1'b1; waitN(1); adcValid = 1'b0;
    chk("R11 adcValid ignored in fixed", {31'b0, wrStrobe}, 0);
    waitN(3);
    chk("R4 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule